// File: doc/BRIEF.md
# Fractional-Duty PWM Channel

This block generates a single pulse-width-modulated output from one of several shared timer counters. The counters and their per-period overflow pulses come in as ports. The channel selects one counter and compares it against two points. At the high point the output turns on. At the low point it turns off. The low point is the high point plus the integer part of a duty word, and the sum wraps within the counter width.

The lowest four bits of the duty word are a fraction. A four-bit phase accumulator advances by that fraction once per period. Each carry out of the accumulator lengthens the pulse of that period by one count. The average pulse length can therefore be set in sixteenths of a count.

The high point and the duty word are written to shadow storage when the update strobe is pulsed. They become active only at the next period boundary of the selected timer, so a period never mixes old and new settings. When the enable is clear, the output pin shows a programmable idle level instead of the pulse train.

Top module: `pwm_frac_chan`

## Requirements
- R1: `tmr_sel_i` chooses the time base. Value k selects counter lane k of `tmr_cnt_i` (bits [k*CNT_W +: CNT_W]) and overflow bit k of `tmr_wrap_i`. So 0 selects timer 0 and 3 selects timer 3.
- R2: The internal level turns high on the clock edge at the end of the cycle in which the selected count equals the active high point. This applies when the low point differs from the high point. `pwm_o` follows the level one cycle after that count is presented.
- R3: The level turns low on the edge at the end of the cycle in which the selected count equals the active low point. The low point is (high point + duty[CNT_W+3:4] + extra) modulo 2^CNT_W. A pulse may therefore span the counter wrap.
- R4: The extra count is 0 or 1 in each period. Over any 16 consecutive periods with a constant duty, exactly duty[3:0] periods have the extra count. Each period is high for either the integer duty or the integer duty plus one counts.
- R5: When the low point equals the high point, the level stays low for the whole period.
- R6: When `out_en_i` is 0, `pwm_o` equals `idle_lvl_i` in the same cycle, whatever the pulse state.
- R7: `hpoint_i` and `duty_i` have no effect unless `upd_i` is high. A strobe stores them. The stored values become active at the first cycle, after the strobe cycle, in which the selected overflow bit is high. The active values never change between overflow cycles.
- R8: After reset, the level is low and the active high point, duty and phase are all zero, with nothing pending. The output therefore stays low while enabled until an update is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt_i | input | N_TMR*CNT_W | Packed timer counter values, lane k = timer k |
| tmr_wrap_i | input | N_TMR | Per-timer overflow bit, high in the cycle that timer's count is 0 |
| tmr_sel_i | input | SEL_W | Timer select |
| out_en_i | input | 1 | Output enable |
| idle_lvl_i | input | 1 | Pin level while disabled |
| hpoint_i | input | CNT_W | High point to be shadowed |
| duty_i | input | CNT_W+4 | Duty: integer part above four fraction bits |
| upd_i | input | 1 | Update strobe for high point and duty |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that the selected overflow bit is high exactly in the cycle the selected count is zero. Between overflows, the active settings and the phase must therefore be frozen, and every compare outside an overflow cycle uses the active points. The stimulus drives all four lanes from one free-running bench counter with fixed offsets of 16 counts, and derives each overflow bit from its own lane being zero. The select is changed only together with an update strobe, and measurements start two selected overflows later, so every window covers whole, steady periods.

// File: rtl/pwmf_pkg.sv
package pwmf_pkg;
    parameter int unsigned FRAC_W = 4;
    typedef logic [FRAC_W-1:0] frac_t;
    typedef struct packed {
        frac_t ph;
        logic  ext;
    } dith_t;
endpackage

// File: rtl/pwmf_tsel.sv
module pwmf_tsel #(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned N_TMR = 4,
    localparam int unsigned SEL_W = $clog2(N_TMR)
) (
    input  logic [N_TMR*CNT_W-1:0] cnt_bus_i,
    input  logic [N_TMR-1:0]       wrap_bus_i,
    input  logic [SEL_W-1:0]       sel_i,
    output logic [CNT_W-1:0]       cnt_o,
    output logic                   wrap_o
);
    logic [CNT_W-1:0] lane [N_TMR];

    for (genvar g = 0; g < N_TMR; g++) begin : g_lane
        assign lane[g] = cnt_bus_i[g*CNT_W +: CNT_W];
    end

    assign cnt_o  = lane[sel_i];
    assign wrap_o = wrap_bus_i[sel_i];
endmodule

// File: rtl/pwmf_shadow.sv
module pwmf_shadow
    import pwmf_pkg::*;
#(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] hp_i,
    input  logic [CNT_W-1:0] int_i,
    input  frac_t            frac_i,
    output logic [CNT_W-1:0] act_hp_o,
    output logic [CNT_W-1:0] act_int_o,
    output logic [CNT_W-1:0] eff_hp_o,
    output logic [CNT_W-1:0] eff_int_o,
    output frac_t            eff_frac_o,
    output logic             pend_o
);
    typedef struct packed {
        logic [CNT_W-1:0] hp;
        logic [CNT_W-1:0] dint;
        frac_t            frac;
    } cfg_t;

    typedef struct packed {
        cfg_t pend;
        cfg_t act;
        logic armed;
    } sh_t;

    sh_t  s_d, s_q;
    logic apply;
    cfg_t eff;

    always_comb begin
        s_d   = s_q;
        apply = wrap_i && s_q.armed;
        if (apply) begin
            s_d.act   = s_q.pend;
            s_d.armed = 1'b0;
        end
        if (upd_i) begin
            s_d.pend  = '{hp: hp_i, dint: int_i, frac: frac_i};
            s_d.armed = 1'b1;
        end
        eff = apply ? s_q.pend : s_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_hp_o   = s_q.act.hp;
    assign act_int_o  = s_q.act.dint;
    assign eff_hp_o   = eff.hp;
    assign eff_int_o  = eff.dint;
    assign eff_frac_o = eff.frac;
    assign pend_o     = s_q.armed;
endmodule

// File: rtl/pwmf_dither.sv
module pwmf_dither
    import pwmf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wrap_i,
    input  frac_t frac_i,
    output logic  ext_eff_o,
    output logic  ext_q_o,
    output frac_t ph_q_o
);
    dith_t             d_d, d_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        d_d = d_q;
        sum = {1'b0, d_q.ph} + {1'b0, frac_i};
        if (wrap_i) begin
            d_d.ph  = sum[FRAC_W-1:0];
            d_d.ext = sum[FRAC_W];
        end
        ext_eff_o = wrap_i ? sum[FRAC_W] : d_q.ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign ext_q_o = d_q.ext;
    assign ph_q_o  = d_q.ph;
endmodule

// File: rtl/pwm_frac_chan.sv
module pwm_frac_chan
    import pwmf_pkg::*;
#(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned N_TMR = 4,
    localparam int unsigned SEL_W  = $clog2(N_TMR),
    localparam int unsigned DUTY_W = CNT_W + FRAC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_TMR*CNT_W-1:0] tmr_cnt_i,
    input  logic [N_TMR-1:0]       tmr_wrap_i,
    input  logic [SEL_W-1:0]       tmr_sel_i,
    input  logic                   out_en_i,
    input  logic                   idle_lvl_i,
    input  logic [CNT_W-1:0]       hpoint_i,
    input  logic [DUTY_W-1:0]      duty_i,
    input  logic                   upd_i,
    output logic                   pwm_o
);
    typedef struct packed {
        logic lvl;
    } out_t;

    logic [CNT_W-1:0] sel_cnt;
    logic             sel_wrap;
    logic [CNT_W-1:0] hp_q, int_q, eff_hp, eff_int;
    frac_t            eff_frac, ph_q;
    logic             pend_q, ext_eff, ext_q;
    logic [CNT_W-1:0] eff_lp, act_lp;
    out_t             o_d, o_q;

    pwmf_tsel #(.CNT_W(CNT_W), .N_TMR(N_TMR)) u_tsel (
        .cnt_bus_i  (tmr_cnt_i),
        .wrap_bus_i (tmr_wrap_i),
        .sel_i      (tmr_sel_i),
        .cnt_o      (sel_cnt),
        .wrap_o     (sel_wrap)
    );

    pwmf_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (upd_i),
        .wrap_i     (sel_wrap),
        .hp_i       (hpoint_i),
        .int_i      (duty_i[DUTY_W-1:FRAC_W]),
        .frac_i     (duty_i[FRAC_W-1:0]),
        .act_hp_o   (hp_q),
        .act_int_o  (int_q),
        .eff_hp_o   (eff_hp),
        .eff_int_o  (eff_int),
        .eff_frac_o (eff_frac),
        .pend_o     (pend_q)
    );

    pwmf_dither u_dither (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (sel_wrap),
        .frac_i    (eff_frac),
        .ext_eff_o (ext_eff),
        .ext_q_o   (ext_q),
        .ph_q_o    (ph_q)
    );

    // low points wrap modulo the counter width
    assign eff_lp = eff_hp + eff_int + {{(CNT_W-1){1'b0}}, ext_eff};
    assign act_lp = hp_q + int_q + {{(CNT_W-1){1'b0}}, ext_q};

    always_comb begin
        o_d = o_q;
        if (sel_cnt == eff_lp)      o_d.lvl = 1'b0;
        else if (sel_cnt == eff_hp) o_d.lvl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pwm_o = out_en_i ? o_q.lvl : idle_lvl_i;
endmodule

// File: rtl/pwmf_chk.sv
module pwmf_chk
    import pwmf_pkg::*;
#(
    parameter int unsigned CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wrap_sel,
    input logic [CNT_W-1:0] cnt_sel,
    input logic [CNT_W-1:0] act_hp,
    input logic [CNT_W-1:0] act_lp,
    input logic             lvl_q,
    input logic             pend_q,
    input logic             upd_i,
    input frac_t            ph_q
);
    // R2
    rise_at_hp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_sel && cnt_sel == act_hp && act_hp != act_lp) |=> lvl_q);

    // R3
    fall_at_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_sel && cnt_sel == act_lp) |=> !lvl_q);

    // R5
    equal_points_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_sel && act_hp == act_lp && !lvl_q) |=> !lvl_q);

    // R7
    hold_between_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_sel |=> ($stable(act_hp) && $stable(act_lp)));

    // R7
    strobe_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> pend_q);

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_sel |=> $stable(ph_q));
endmodule

bind pwm_frac_chan pwmf_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_sel (sel_wrap),
    .cnt_sel  (sel_cnt),
    .act_hp   (hp_q),
    .act_lp   (act_lp),
    .lvl_q    (o_q.lvl),
    .pend_q   (pend_q),
    .upd_i    (upd_i),
    .ph_q     (ph_q)
);

// File: tb/tb_pwm_frac_chan.sv
module tb_pwm_frac_chan;
    localparam int CW = 6;
    localparam int NT = 4;
    localparam int P  = 64;
    localparam int NV = 8;

    typedef struct packed {
        logic [1:0] sel;
        logic [5:0] hp;
        logic [5:0] dint;
        logic [3:0] frac;
        logic [7:0] rise;   // 8'hFF: no high expected, 8'hFE: not checked
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{2'd0, 6'd10, 6'd20, 4'd0,  8'd10},
        '{2'd1, 6'd5,  6'd8,  4'd3,  8'd5},
        '{2'd2, 6'd0,  6'd32, 4'd15, 8'd0},
        '{2'd3, 6'd30, 6'd1,  4'd8,  8'd30},
        '{2'd0, 6'd20, 6'd0,  4'd0,  8'hFF},
        '{2'd1, 6'd7,  6'd0,  4'd5,  8'hFE},
        '{2'd2, 6'd60, 6'd10, 4'd0,  8'd0},
        '{2'd3, 6'd50, 6'd20, 4'd4,  8'd0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NT*CW-1:0] tcnt;
    logic [NT-1:0]   twrap;
    logic [1:0]      sel = 2'd0;
    logic            out_en = 1'b1;
    logic            idle = 1'b0;
    logic            upd = 1'b0;
    logic [CW-1:0]   hp_in = '0;
    logic [CW+3:0]   duty_in = '0;
    logic            pwm;
    int              c = 0;
    int              checks = 0;
    int              errors = 0;

    always #4 clk = ~clk;

    for (genvar k = 0; k < NT; k++) begin : g_tmr
        assign tcnt[k*CW +: CW] = CW'(c + 16 * k);
        assign twrap[k]         = (tcnt[k*CW +: CW] == '0);
    end

    pwm_frac_chan #(.CNT_W(CW), .N_TMR(NT)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_cnt_i  (tcnt),
        .tmr_wrap_i (twrap),
        .tmr_sel_i  (sel),
        .out_en_i   (out_en),
        .idle_lvl_i (idle),
        .hpoint_i   (hp_in),
        .duty_i     (duty_in),
        .upd_i      (upd),
        .pwm_o      (pwm)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // sample the output (it reflects the count presented one cycle earlier), then advance
    task automatic tick(input logic u, output logic s, output int rc);
        @(negedge clk);
        s  = pwm;
        rc = int'(CW'(c + 16 * int'(sel)));
        c  = c + 1;
        upd = u;
    endtask

    task automatic sync(output logic s);
        int rc;
        do tick(1'b0, s, rc); while (rc != 0);
    endtask

    task automatic measure(output int total, output int rise, output int pmin, output int pmax);
        logic s;
        int   rc;
        int   per;
        total = 0; rise = -1; pmin = P + 1; pmax = -1; per = 0;
        sync(s);
        for (int i = 0; i < 16 * P; i++) begin
            if (i > 0) tick(1'b0, s, rc);
            if (s) begin
                total++;
                per++;
                if (rise < 0) rise = i;
            end
            if (i % P == P - 1) begin
                if (per < pmin) pmin = per;
                if (per > pmax) pmax = per;
                per = 0;
            end
        end
    endtask

    task automatic apply(input logic [1:0] sv, input logic [5:0] h, input logic [5:0] di,
                         input logic [3:0] f);
        logic s;
        int   rc;
        sel = sv; hp_in = h; duty_in = {di, f};
        tick(1'b1, s, rc);
        tick(1'b0, s, rc);   // reflects the strobe cycle itself
        sync(s);             // first selected overflow after the strobe applies it
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic s;
        int   rc, tot, rise, pmin, pmax, bad;

        for (int i = 0; i < 4; i++) tick(1'b0, s, rc);
        chk(s == 1'b0, "R8 output in reset", int'(s), 0);
        rst_n = 1'b1;
        measure(tot, rise, pmin, pmax);
        chk(tot == 0, "R8 low after reset", tot, 0);

        foreach (VEC[v]) begin
            apply(VEC[v].sel, VEC[v].hp, VEC[v].dint, VEC[v].frac);
            measure(tot, rise, pmin, pmax);
            chk(tot == 16 * int'(VEC[v].dint) + int'(VEC[v].frac), "R3 R4 R5 total high",
                tot, 16 * int'(VEC[v].dint) + int'(VEC[v].frac));
            chk(pmin >= int'(VEC[v].dint) && pmax <= int'(VEC[v].dint) + 1,
                "R4 per-period length", pmax, int'(VEC[v].dint));
            if (VEC[v].rise == 8'hFF)
                chk(rise == -1, "R5 never high", rise, -1);
            else if (VEC[v].rise != 8'hFE)
                chk(rise == int'(VEC[v].rise), "R1 R2 rise index", rise, int'(VEC[v].rise));
        end

        // R7: inputs change without a strobe, pattern must stay on the old settings
        apply(2'd0, 6'd10, 6'd20, 4'd0);
        hp_in = 6'd40; duty_in = {6'd5, 4'd9};
        sync(s);
        measure(tot, rise, pmin, pmax);
        chk(tot == 320, "R7 no strobe total", tot, 320);
        chk(rise == 10, "R7 no strobe rise", rise, 10);

        // R6: idle level while disabled
        out_en = 1'b0; idle = 1'b1; bad = 0;
        for (int i = 0; i < P; i++) begin
            tick(1'b0, s, rc);
            if (s != 1'b1) bad++;
        end
        chk(bad == 0, "R6 idle high", bad, 0);
        idle = 1'b0; bad = 0;
        for (int i = 0; i < P; i++) begin
            tick(1'b0, s, rc);
            if (s != 1'b0) bad++;
        end
        chk(bad == 0, "R6 idle low", bad, 0);
        out_en = 1'b1;
        measure(tot, rise, pmin, pmax);
        chk(tot == 320, "R6 re-enabled", tot, 320);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule